// File: doc/BRIEF.md
# Branch Order Buffer with Fast Recovery

This block keeps an age-ordered list of the conditional and indirect branches that are in flight in an out-of-order core. Each entry stands for one branch that the front end has predicted and that no execute unit has resolved yet. Unconditional direct branches are settled at decode and never reach this block. The front end takes an entry through a valid/ready allocation port and receives a tag. The tag is a slot index plus a wrap bit, so the age of any two live tags can be compared. Execute units later return the tag with the real outcome, in any order and on several ports in the same cycle.

An entry is released the moment its branch resolves, whether the prediction held or not. It does not wait for retirement. When a resolution reports a mispredict, the block recovers at once, even if instructions older than the branch are still executing. It issues a one-cycle redirect that carries the correct target and the tag of the faulty branch. That tag doubles as the flush tag for the rest of the core. Every younger entry is dropped, and the next allocation reuses the slot just after the mispredicted one. A branch that is fetched again on the correct path is treated as a new branch.

Allocation back-pressure: `alloc_tag` shows the tag the next branch will receive. An allocation happens on a clock edge where `alloc_valid` and `alloc_ready` are both high. The front end may raise or drop `alloc_valid` at any time. `alloc_ready` does not depend on `alloc_valid`. Resolution ports have no back-pressure: a valid resolution is always accepted in the cycle it is presented.

Top module: `brob_top`

## Requirements
- R1: Out of reset `alloc_ready` is 1, `alloc_tag` is 0 and `redir_valid` is 0. Tags are {wrap bit, slot index}, with the wrap bit as the MSB. Successive allocations receive slot indices 0 to DEPTH-1 in turn. After slot DEPTH-1 the index returns to 0 and the wrap bit toggles.
- R2: Occupancy is the distance from the oldest unreleased slot to the tail. When it equals DEPTH, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R3: A resolution with `res_mispredict`=0 for a live tag releases the entry and produces no redirect.
- R4: Releasing the oldest entry frees a slot for allocation at the next edge. The oldest-slot pointer then steps over already-released slots, one slot per cycle. A released slot with an older live entry still before it is not yet reusable.
- R5: A resolution with `res_mispredict`=1 for a live tag drives `redir_valid` high for exactly one cycle, starting one cycle later. In that cycle `redir_pc` equals the resolution's target and `redir_tag` equals its tag.
- R6: On recovery, all entries younger than the mispredicted tag are discarded, and later resolutions of those tags cause no redirect. The next allocated tag is the one that follows the mispredicted tag.
- R7: Entries older than a mispredicted branch survive its recovery and can still resolve and redirect later.
- R8: If several live mispredicts resolve in the same cycle, only the oldest produces the redirect, whichever port it arrives on.
- R9: `alloc_ready` is 0 during the redirect cycle, and `alloc_valid` has no effect in that cycle.
- R10: A resolution whose tag is not live has no effect. This covers a released tag, a tag whose wrap bit differs from the stored one, and a slot index of DEPTH or more.
- R11: Resolutions of live entries may arrive in any order, and each releases only its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Front end requests an entry for a predicted branch |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_tag | output | IDX_W+1 | Tag given to the branch allocated this cycle |
| res_valid | input | NUM_RES | Per-port resolution strobe |
| res_tag | input | NUM_RES*(IDX_W+1) | Per-port tag of the resolving branch |
| res_mispredict | input | NUM_RES | Per-port flag: the prediction was wrong |
| res_target | input | NUM_RES*PC_W | Per-port correct next PC |
| redir_valid | output | 1 | One-cycle recovery pulse |
| redir_pc | output | PC_W | PC to refetch from |
| redir_tag | output | IDX_W+1 | Tag of the mispredicted branch; everything younger is flushed |

## Verification
The assertions assume the front end obeys `alloc_ready`. They also assume an execute unit never reports a tag that was squashed and has since been handed out again, because such a report would look live. The bench drives allocations only through a handshake task that waits for ready. After each squash it sends the stale-tag resolutions before any new allocation can reuse those slots. A small configuration of five slots and two resolution ports lets the sequence reach full occupancy, wrap-around and both port orders of simultaneous mispredicts.

// File: rtl/brob_pkg.sv
package brob_pkg;

  // Position of a tag on a ring twice the buffer depth long.
  function automatic int unsigned ring_pos(input logic wrap, input int unsigned idx,
                                           input int unsigned depth);
    return wrap ? (depth + idx) : idx;
  endfunction

  // Distance from the oldest slot; a larger value means a younger branch.
  function automatic int unsigned ring_age(input int unsigned pos, input int unsigned head_pos,
                                           input int unsigned depth);
    return (pos >= head_pos) ? (pos - head_pos) : (pos + 2 * depth - head_pos);
  endfunction

  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned depth);
    return (pos + 1 == 2 * depth) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/brob_ptr.sv
module brob_ptr
  import brob_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6,
  parameter int TAG_W = 7,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             recover,
  input  logic [TAG_W-1:0] recover_tag,
  input  logic [DEPTH-1:0] valid_next,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] tail_tag,
  output logic [CNT_W-1:0] occupancy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

  logic [TAG_W-1:0] head_q, tail_q, head_d, tail_d;

  function automatic logic [TAG_W-1:0] tag_inc(input logic [TAG_W-1:0] t);
    if (t[IDX_W-1:0] == LAST_IDX) return {~t[IDX_W], {IDX_W{1'b0}}};
    return {t[IDX_W], t[IDX_W-1:0] + IDX_W'(1)};
  endfunction

  always_comb begin
    tail_d = tail_q;
    if (recover)         tail_d = tag_inc(recover_tag);
    else if (alloc_fire) tail_d = tag_inc(tail_q);
  end

  // The oldest pointer steps over one released slot per cycle.
  always_comb begin
    head_d = head_q;
    if ((head_q != tail_q) && !valid_next[head_q[IDX_W-1:0]]) head_d = tag_inc(head_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_tag  = head_q;
  assign tail_tag  = tail_q;
  assign occupancy = CNT_W'(ring_age(ring_pos(tail_q[IDX_W], 32'(tail_q[IDX_W-1:0]), DEPTH),
                                     ring_pos(head_q[IDX_W], 32'(head_q[IDX_W-1:0]), DEPTH),
                                     DEPTH));

  // R2: the allocation handshake never lets occupancy pass capacity.
  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= DEPTH_C);

endmodule

// File: rtl/brob_slots.sv
module brob_slots
  import brob_pkg::*;
#(
  parameter int DEPTH   = 48,
  parameter int NUM_RES = 2,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_set,
  input  logic [TAG_W-1:0]         tail_tag,
  input  logic [TAG_W-1:0]         head_tag,
  input  logic [NUM_RES-1:0]       res_valid,
  input  logic [NUM_RES*TAG_W-1:0] res_tag_flat,
  input  logic                     squash,
  input  logic [TAG_W-1:0]         squash_tag,
  output logic [NUM_RES-1:0]       res_hit,
  output logic [DEPTH-1:0]         valid_next
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0] valid_q, wrap_q, free_mask, young_mask, set_mask;
  logic [IDX_W-1:0] res_idx [NUM_RES];
  int unsigned      head_pos, squash_age;

  assign head_pos   = ring_pos(head_tag[IDX_W], 32'(head_tag[IDX_W-1:0]), DEPTH);
  assign squash_age = ring_age(ring_pos(squash_tag[IDX_W], 32'(squash_tag[IDX_W-1:0]), DEPTH),
                               head_pos, DEPTH);

  // A resolution hits only a live slot whose stored wrap bit matches the tag.
  for (genvar p = 0; p < NUM_RES; p++) begin : g_port
    logic [TAG_W-1:0] t;
    assign t          = res_tag_flat[p*TAG_W +: TAG_W];
    assign res_idx[p] = t[IDX_W-1:0];
    assign res_hit[p] = res_valid[p] && (res_idx[p] <= LAST_IDX) &&
                        valid_q[res_idx[p]] && (wrap_q[res_idx[p]] == t[IDX_W]);
  end

  always_comb begin
    free_mask = '0;
    for (int p = 0; p < NUM_RES; p++) begin
      if (res_hit[p]) free_mask[res_idx[p]] = 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    int unsigned age_i;
    assign age_i = ring_age(ring_pos(wrap_q[i], i, DEPTH), head_pos, DEPTH);
    assign young_mask[i] = squash && valid_q[i] && (age_i > squash_age);
    assign set_mask[i]   = alloc_set && !squash && (tail_tag[IDX_W-1:0] == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)           wrap_q[i] <= 1'b0;
      else if (set_mask[i]) wrap_q[i] <= tail_tag[IDX_W];
    end

    // R3 / R11: a resolved slot is released at the next edge.
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      free_mask[i] |=> !valid_q[i]);
    // R6: a slot younger than a mispredict is discarded.
    a_r6_discard_young: assert property (@(posedge clk) disable iff (!rst_n)
      young_mask[i] |=> !valid_q[i]);
    // R1: an allocated slot becomes live with the tail's wrap bit.
    a_r1_slot_live: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[i] |=> (valid_q[i] && (wrap_q[i] == $past(tail_tag[IDX_W]))));
  end

  assign valid_next = (valid_q & ~free_mask & ~young_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_next;
  end

endmodule

// File: rtl/brob_pick.sv
module brob_pick
  import brob_pkg::*;
#(
  parameter int DEPTH   = 48,
  parameter int NUM_RES = 2,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 7,
  parameter int PC_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_RES-1:0]       cand,
  input  logic [NUM_RES*TAG_W-1:0] tag_flat,
  input  logic [NUM_RES*PC_W-1:0]  target_flat,
  input  logic [TAG_W-1:0]         head_tag,
  output logic                     win_valid,
  output logic [TAG_W-1:0]         win_tag,
  output logic [PC_W-1:0]          win_target
);

  int unsigned      head_pos, win_age;
  int unsigned      age_p [NUM_RES];
  logic [NUM_RES-1:0] win_sel;

  assign head_pos = ring_pos(head_tag[IDX_W], 32'(head_tag[IDX_W-1:0]), DEPTH);

  for (genvar p = 0; p < NUM_RES; p++) begin : g_age
    logic [TAG_W-1:0] t;
    assign t        = tag_flat[p*TAG_W +: TAG_W];
    assign age_p[p] = ring_age(ring_pos(t[IDX_W], 32'(t[IDX_W-1:0]), DEPTH), head_pos, DEPTH);

    // R8: no live mispredict older than the winner goes unselected.
    a_r8_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && cand[p]) |-> (win_age <= age_p[p]));
  end

  // Oldest live mispredict among the ports wins.
  always_comb begin
    win_valid  = 1'b0;
    win_tag    = '0;
    win_target = '0;
    win_sel    = '0;
    win_age    = 0;
    for (int p = 0; p < NUM_RES; p++) begin
      if (cand[p] && (!win_valid || age_p[p] < win_age)) begin
        win_valid  = 1'b1;
        win_age    = age_p[p];
        win_tag    = tag_flat[p*TAG_W +: TAG_W];
        win_target = target_flat[p*PC_W +: PC_W];
        win_sel    = '0;
        win_sel[p] = 1'b1;
      end
    end
  end

  // R8: at most one port drives the redirect.
  a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel) && (win_valid == (cand != '0)));

endmodule

// File: rtl/brob_top.sv
module brob_top
  import brob_pkg::*;
#(
  parameter int DEPTH   = 48,
  parameter int NUM_RES = 2,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TAG_W  = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  output logic [TAG_W-1:0]         alloc_tag,
  input  logic [NUM_RES-1:0]       res_valid,
  input  logic [NUM_RES*TAG_W-1:0] res_tag,
  input  logic [NUM_RES-1:0]       res_mispredict,
  input  logic [NUM_RES*PC_W-1:0]  res_target,
  output logic                     redir_valid,
  output logic [PC_W-1:0]          redir_pc,
  output logic [TAG_W-1:0]         redir_tag
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [TAG_W-1:0]   head_tag, tail_tag, win_tag;
  logic [CNT_W-1:0]   occupancy;
  logic [DEPTH-1:0]   valid_next;
  logic [NUM_RES-1:0] res_hit;
  logic               alloc_fire, win_valid;
  logic [PC_W-1:0]    win_target;
  logic               redir_valid_q;
  logic [PC_W-1:0]    redir_pc_q;
  logic [TAG_W-1:0]   redir_tag_q;

  assign alloc_ready = (occupancy < DEPTH_C) && !redir_valid_q;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_tag;

  brob_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) ptr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .recover    (win_valid),
    .recover_tag(win_tag),
    .valid_next (valid_next),
    .head_tag   (head_tag),
    .tail_tag   (tail_tag),
    .occupancy  (occupancy)
  );

  brob_slots #(.DEPTH(DEPTH), .NUM_RES(NUM_RES), .IDX_W(IDX_W), .TAG_W(TAG_W)) slots_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_set   (alloc_fire),
    .tail_tag    (tail_tag),
    .head_tag    (head_tag),
    .res_valid   (res_valid),
    .res_tag_flat(res_tag),
    .squash      (win_valid),
    .squash_tag  (win_tag),
    .res_hit     (res_hit),
    .valid_next  (valid_next)
  );

  brob_pick #(.DEPTH(DEPTH), .NUM_RES(NUM_RES), .IDX_W(IDX_W), .TAG_W(TAG_W),
              .PC_W(PC_W)) pick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand       (res_hit & res_mispredict),
    .tag_flat   (res_tag),
    .target_flat(res_target),
    .head_tag   (head_tag),
    .win_valid  (win_valid),
    .win_tag    (win_tag),
    .win_target (win_target)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid_q <= 1'b0;
      redir_pc_q    <= '0;
      redir_tag_q   <= '0;
    end else begin
      redir_valid_q <= win_valid;
      if (win_valid) begin
        redir_pc_q  <= win_target;
        redir_tag_q <= win_tag;
      end
    end
  end

  assign redir_valid = redir_valid_q;
  assign redir_pc    = redir_pc_q;
  assign redir_tag   = redir_tag_q;

  // R5: every redirect follows a reported mispredict one cycle earlier.
  a_r5_redir_cause: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past((res_valid & res_mispredict) != '0));
  // R6: during the redirect the tail sits just after the faulty branch.
  a_r6_tail_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (ring_pos(tail_tag[IDX_W], 32'(tail_tag[IDX_W-1:0]), DEPTH) ==
                     ring_next(ring_pos(redir_tag[IDX_W], 32'(redir_tag[IDX_W-1:0]), DEPTH),
                               DEPTH)));
  // R9: nothing is allocated across the redirect cycle.
  a_r9_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (occupancy <= $past(occupancy)));

endmodule

// File: tb/brob_top_tb_top.sv
`timescale 1ns/1ps
module brob_top_tb_top;

  localparam int DEPTH = 5;
  localparam int NRES  = 2;
  localparam int PCW   = 16;
  localparam int TW    = $clog2(DEPTH) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            alloc_valid = 1'b0;
  logic            alloc_ready;
  logic [TW-1:0]   alloc_tag;
  logic [NRES-1:0] res_valid = '0;
  logic [NRES*TW-1:0]  res_tag = '0;
  logic [NRES-1:0]     res_mispredict = '0;
  logic [NRES*PCW-1:0] res_target = '0;
  logic            redir_valid;
  logic [PCW-1:0]  redir_pc;
  logic [TW-1:0]   redir_tag;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  brob_top #(.DEPTH(DEPTH), .NUM_RES(NRES), .PC_W(PCW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict),
    .res_target(res_target),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_tag(redir_tag)
  );

  function automatic logic [TW-1:0] tg(input int w, input int i);
    return TW'(w * (1 << (TW - 1)) + i);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // Entered and left at a falling edge.
  task automatic alloc_one(input logic [TW-1:0] exp_tag, input string req);
    alloc_valid = 1'b1;
    #1;
    chk(req, "alloc_ready", 32'(alloc_ready), 32'd1);
    chk(req, "alloc_tag", 32'(alloc_tag), 32'(exp_tag));
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic res2(input logic v0, input logic [TW-1:0] t0, input logic m0,
                      input logic [PCW-1:0] p0, input logic v1, input logic [TW-1:0] t1,
                      input logic m1, input logic [PCW-1:0] p1);
    res_valid      = {v1, v0};
    res_tag        = {t1, t0};
    res_mispredict = {m1, m0};
    res_target     = {p1, p0};
    @(negedge clk);
    res_valid = '0;
    res_mispredict = '0;
  endtask

  task automatic expect_redirect(input logic [TW-1:0] t, input logic [PCW-1:0] pc,
                                 input string req);
    chk(req, "redir_valid", 32'(redir_valid), 32'd1);
    chk(req, "redir_tag", 32'(redir_tag), 32'(t));
    chk(req, "redir_pc", 32'(redir_pc), 32'(pc));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "reset alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1", "reset alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R1", "reset redir_valid", 32'(redir_valid), 32'd0);

    // R1: sequential tags up to capacity
    for (int i = 0; i < DEPTH; i++) alloc_one(tg(0, i), "R1");
    // R2: full stalls, request ignored
    chk("R2", "full alloc_ready", 32'(alloc_ready), 32'd0);
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
    chk("R2", "still full", 32'(alloc_ready), 32'd0);

    // R3/R4: correct resolve of oldest frees a slot, no redirect
    res2(1'b1, tg(0, 0), 1'b0, 16'h0100, 1'b0, '0, 1'b0, 16'h0);
    chk("R3", "no redirect on confirm", 32'(redir_valid), 32'd0);
    chk("R4", "slot reclaimed", 32'(alloc_ready), 32'd1);
    alloc_one(tg(1, 0), "R1 wrap");
    chk("R2", "full again", 32'(alloc_ready), 32'd0);

    // R11/R4: out of order; a hole behind a live older entry is not reusable
    res2(1'b0, '0, 1'b0, 16'h0, 1'b1, tg(0, 3), 1'b0, 16'h0300);
    chk("R11", "no redirect", 32'(redir_valid), 32'd0);
    chk("R4", "hole not reusable", 32'(alloc_ready), 32'd0);
    res2(1'b1, tg(0, 1), 1'b0, 16'h0110, 1'b0, '0, 1'b0, 16'h0);
    chk("R11", "no redirect", 32'(redir_valid), 32'd0);
    chk("R4", "oldest freed", 32'(alloc_ready), 32'd1);
    res2(1'b0, '0, 1'b0, 16'h0, 1'b1, tg(0, 2), 1'b0, 16'h0);
    repeat (2) @(negedge clk);

    // R10: stale, wrong-wrap, out-of-range tags do nothing
    res2(1'b1, tg(0, 3), 1'b1, 16'hBAD0, 1'b0, '0, 1'b0, 16'h0);
    chk("R10", "released tag", 32'(redir_valid), 32'd0);
    res2(1'b1, tg(1, 4), 1'b1, 16'hBAD1, 1'b1, tg(1, 6), 1'b1, 16'hBAD2);
    chk("R10", "wrap mismatch / range", 32'(redir_valid), 32'd0);

    // live: 4, 8 -> add 9, 10, 11 (tail state unchanged by R10 stimulus)
    alloc_one(tg(1, 1), "R10");
    alloc_one(tg(1, 2), "R1");
    alloc_one(tg(1, 3), "R1");
    chk("R2", "full with holes cleared", 32'(alloc_ready), 32'd0);

    // R8: younger on port0, older on port1; older wins
    res2(1'b1, tg(1, 2), 1'b1, 16'h01A0, 1'b1, tg(1, 0), 1'b1, 16'h02B0);
    expect_redirect(tg(1, 0), 16'h02B0, "R8");
    // R9: blocked during redirect cycle
    alloc_valid = 1'b1;
    #1;
    chk("R9", "alloc_ready in redirect", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    alloc_valid = 1'b0;
    chk("R5", "pulse length", 32'(redir_valid), 32'd0);
    // R6: squashed tags ignored
    res2(1'b1, tg(1, 2), 1'b1, 16'hBAD3, 1'b0, '0, 1'b0, 16'h0);
    chk("R6", "squashed resolve", 32'(redir_valid), 32'd0);
    res2(1'b0, '0, 1'b0, 16'h0, 1'b1, tg(1, 1), 1'b1, 16'hBAD4);
    chk("R6", "squashed resolve", 32'(redir_valid), 32'd0);
    alloc_one(tg(1, 1), "R6 R9 next tag");

    // R7: older entry 4 survived and still redirects
    res2(1'b1, tg(0, 4), 1'b1, 16'h03C0, 1'b0, '0, 1'b0, 16'h0);
    expect_redirect(tg(0, 4), 16'h03C0, "R7");
    @(negedge clk);
    chk("R5", "pulse length", 32'(redir_valid), 32'd0);
    alloc_one(tg(1, 0), "R6 next tag");
    alloc_one(tg(1, 1), "R1");

    // R8: older on port0 this time
    res2(1'b1, tg(1, 0), 1'b1, 16'h04D0, 1'b1, tg(1, 1), 1'b1, 16'h05E0);
    expect_redirect(tg(1, 0), 16'h04D0, "R8");
    @(negedge clk);
    alloc_one(tg(1, 1), "R6");

    summary();
    $finish;
  end

endmodule